// File: doc/BRIEF.md
# Programmable Clock Phase Delay Controller

This block places sampling strobes at a programmable phase inside a reference clock period. A fast step clock divides each reference period into 2^STEP_W fine steps; the default is 64 steps, so one step is 5.625 degrees. A pulse on `periodStart` marks step 0. A free-running step counter gives the position within the period. Each channel fires its main strobe when the counter reaches the channel's programmed setting. It fires a companion strobe half a period later, which gives the two sampling clocks of one channel the inverted, 180 degree relation they need for interleaved capture. With the default two channels there are four phase-adjustable strobe outputs.

A new setting is captured with a per-channel load strobe. It is applied only at a period boundary, so a strobe is never doubled or cut inside a period. Each channel reports the active phase as whole degrees, equal to setting × 360 / 2^STEP_W rounded down. If the reference pulse is missing for TIMEOUT_STEPS steps, an error flag rises and all strobes stay low until the reference returns.

Top module: `phase_delay_ctrl`

## Requirements
- R1: While `rstN` is low, every bit of `pulseOut`, `phaseDeg` and `errFlag` is 0, and all active settings are 0.
- R2: The step position is 0 in a cycle where `periodStart` is high and rises by one in each later cycle. Channel c's main strobe, `pulseOut[2c]`, is high for exactly the one cycle after the cycle whose step position equals the channel's active setting. A setting of 0 therefore fires one cycle after the period start.
- R3: Channel c's companion strobe, `pulseOut[2c+1]`, fires in the same way at step (setting + 2^(STEP_W-1)) mod 2^STEP_W, which is 180 degrees away. For example, setting 32 of 64 puts the companion at step 0.
- R4: When `phaseLoad[c]` is high, the setting on `phaseSetting[c*STEP_W +: STEP_W]` is stored as pending. It becomes active only at the first `periodStart` in a later cycle. A load in the same cycle as a start waits for the following start. Values on `phaseSetting` without a load have no effect.
- R5: Each strobe output pulses at most once per reference period.
- R6: `phaseDeg[c*9 +: 9]` equals floor(active setting × 360 / 2^STEP_W). It changes only in the cycle after a `periodStart`.
- R7: Once TIMEOUT_STEPS steps pass with no `periodStart`, `errFlag` is high from the next cycle on. While it is high, all strobes stay low. It clears in the cycle after the next `periodStart`.
- R8: Channels are independent. A load on one channel leaves the other channel's strobes and degree report unchanged.
- R9: After reset, the step counter starts in the timed-out state. `errFlag` rises after the first clock edge, and no strobe fires before the first `periodStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine step clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodStart | input | 1 | One-cycle marker of reference period start (step 0) |
| phaseLoad | input | NUM_CH | Per-channel setting load strobe |
| phaseSetting | input | NUM_CH*STEP_W | Packed per-channel phase settings in steps |
| pulseOut | output | 2*NUM_CH | Strobes; bit 2c main, bit 2c+1 companion of channel c |
| phaseDeg | output | NUM_CH*9 | Packed per-channel active phase in whole degrees |
| errFlag | output | 1 | Reference period missing |

## Verification
The bench builds the block with its defaults: two channels, 64 steps per period and a 128-step timeout. These values bring the extreme settings 0 and 63 within a short run, along with the wrap of the companion strobe past the period end and the 180 degree setting of 32. The bench also drives reference periods shorter and longer than 64 steps and a gap long enough to reach the timeout. A behavioural model predicts every strobe, degree value and error bit on each clock. Each load lands mid-period, on a period start, or without a strobe.

// File: rtl/phdly_pkg.sv
package phdly_pkg;

  localparam int DEG_W = 9;

  typedef struct packed {
    logic restart;
    logic timedOut;
  } phCtl_t;

  function automatic logic [DEG_W-1:0] stepToDeg(input int unsigned setting,
                                                 input int unsigned stepW);
    int unsigned prod;
    prod = setting * 360;
    return DEG_W'(prod >> stepW);
  endfunction

endpackage

// File: rtl/phdly_ctrl.sv
module phdly_ctrl
  import phdly_pkg::*;
#(
  parameter int TIMEOUT_STEPS = 128,
  localparam int CNT_W = $clog2(TIMEOUT_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStart,
  output phCtl_t           ctl,
  output logic [CNT_W-1:0] curStep,
  output logic             errFlag
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_STEPS);

  logic [CNT_W-1:0] stepCnt;

  // position of the current cycle within the reference period, saturating
  always_comb begin
    if (periodStart) begin
      curStep = '0;
    end else if (stepCnt >= LIMIT) begin
      curStep = LIMIT;
    end else begin
      curStep = stepCnt + 1'b1;
    end
    ctl.restart  = periodStart;
    ctl.timedOut = (curStep == LIMIT);
  end

  // reset lands in the saturated state: no reference seen yet
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= LIMIT;
      errFlag <= 1'b0;
    end else begin
      stepCnt <= curStep;
      errFlag <= ctl.timedOut;
    end
  end

endmodule

// File: rtl/phdly_lane.sv
module phdly_lane
  import phdly_pkg::*;
#(
  parameter int STEP_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  phCtl_t            ctl,
  input  logic [CNT_W-1:0]  curStep,
  input  logic              load,
  input  logic [STEP_W-1:0] setting,
  output logic              pulseMain,
  output logic              pulseHalf,
  output logic [DEG_W-1:0]  phaseDeg
);

  localparam logic [STEP_W-1:0] HALF = {1'b1, {(STEP_W-1){1'b0}}};

  logic [STEP_W-1:0] pendingSet;
  logic [STEP_W-1:0] activeSet;
  logic [STEP_W-1:0] nextAct;
  logic [STEP_W-1:0] halfAct;
  logic              hitMain;
  logic              hitHalf;

  always_comb begin
    nextAct = ctl.restart ? pendingSet : activeSet;
    halfAct = nextAct + HALF;  // wraps modulo the period
    hitMain = (curStep == CNT_W'(nextAct)) && !ctl.timedOut;
    hitHalf = (curStep == CNT_W'(halfAct)) && !ctl.timedOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingSet <= '0;
      activeSet  <= '0;
      pulseMain  <= 1'b0;
      pulseHalf  <= 1'b0;
      phaseDeg   <= '0;
    end else begin
      if (load) begin
        pendingSet <= setting;
      end
      activeSet <= nextAct;
      pulseMain <= hitMain;
      pulseHalf <= hitHalf;
      phaseDeg  <= stepToDeg(int'(nextAct), STEP_W);
    end
  end

endmodule

// File: rtl/phase_delay_ctrl.sv
module phase_delay_ctrl
  import phdly_pkg::*;
#(
  parameter int NUM_CH        = 2,
  parameter int STEP_W        = 6,
  parameter int TIMEOUT_STEPS = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     periodStart,
  input  logic [NUM_CH-1:0]        phaseLoad,
  input  logic [NUM_CH*STEP_W-1:0] phaseSetting,
  output logic [2*NUM_CH-1:0]      pulseOut,
  output logic [NUM_CH*DEG_W-1:0]  phaseDeg,
  output logic                     errFlag
);

  localparam int CNT_W = $clog2(TIMEOUT_STEPS + 1);

  phCtl_t           ctl;
  logic [CNT_W-1:0] curStep;

  phdly_ctrl #(.TIMEOUT_STEPS(TIMEOUT_STEPS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .periodStart(periodStart),
    .ctl        (ctl),
    .curStep    (curStep),
    .errFlag    (errFlag)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    phdly_lane #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .ctl      (ctl),
      .curStep  (curStep),
      .load     (phaseLoad[ch]),
      .setting  (phaseSetting[ch*STEP_W +: STEP_W]),
      .pulseMain(pulseOut[2*ch]),
      .pulseHalf(pulseOut[2*ch+1]),
      .phaseDeg (phaseDeg[ch*DEG_W +: DEG_W])
    );
  end

endmodule

// File: rtl/phase_delay_ctrl_chk.sv
module phase_delay_ctrl_chk
  import phdly_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    periodStart,
  input logic [2*NUM_CH-1:0]     pulseOut,
  input logic [NUM_CH*DEG_W-1:0] phaseDeg,
  input logic                    errFlag
);

  logic startSeen;
  logic startD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startSeen <= 1'b0;
      startD    <= 1'b0;
    end else begin
      startSeen <= startSeen | periodStart;
      startD    <= periodStart;
    end
  end

  // R9: nothing fires before the first reference pulse
  a_r9_quiet_before_sync: assert property (@(posedge clk) disable iff (!rstN)
    !startSeen |-> (pulseOut == '0));

  // R7: strobes suppressed while the reference is missing
  a_r7_quiet_in_error: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (pulseOut == '0));

  // R7: a reference pulse clears the error in the next cycle
  a_r7_error_clears: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !errFlag);

  // R6: degree report moves only right after a period start
  a_r6_deg_only_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !startD |-> $stable(phaseDeg));

  // R5: at most one pulse per output per period
  for (genvar k = 0; k < 2*NUM_CH; k++) begin : g_once
    logic [1:0] pulseCnt;
    logic [1:0] nextCnt;
    always_comb begin
      if (startD) nextCnt = {1'b0, pulseOut[k]};
      else if (pulseCnt == 2'd3) nextCnt = pulseCnt;
      else nextCnt = pulseCnt + {1'b0, pulseOut[k]};
    end
    always_ff @(posedge clk) begin
      if (!rstN) pulseCnt <= '0;
      else pulseCnt <= nextCnt;
    end
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
      nextCnt <= 2'd1);
  end

endmodule

bind phase_delay_ctrl phase_delay_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .periodStart(periodStart),
  .pulseOut   (pulseOut),
  .phaseDeg   (phaseDeg),
  .errFlag    (errFlag)
);

// File: tb/phase_delay_ctrl_tb.sv
module phase_delay_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int SW   = 6;
  localparam int NSTEP = 64;
  localparam int TO   = 128;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            periodStart = 1'b0;
  logic [NCH-1:0]  phaseLoad = '0;
  logic [NCH*SW-1:0] phaseSetting = '0;
  logic [2*NCH-1:0] pulseOut;
  logic [NCH*9-1:0] phaseDeg;
  logic            errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int  mCnt;
  int  mPend[NCH];
  int  mAct[NCH];
  bit  ePulse[2*NCH];
  int  eDeg[NCH];
  bit  eErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_delay_ctrl u_dut (
    .clk(clk), .rstN(rstN), .periodStart(periodStart), .phaseLoad(phaseLoad),
    .phaseSetting(phaseSetting), .pulseOut(pulseOut), .phaseDeg(phaseDeg),
    .errFlag(errFlag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    for (int c = 0; c < NCH; c++) begin
      chk("R2", $sformatf("main strobe ch%0d", c), int'(pulseOut[2*c]), int'(ePulse[2*c]));
      chk("R3", $sformatf("companion strobe ch%0d", c), int'(pulseOut[2*c+1]), int'(ePulse[2*c+1]));
      chk("R6", $sformatf("degrees ch%0d", c), int'(phaseDeg[c*9 +: 9]), eDeg[c]);
    end
    chk("R7", "errFlag", int'(errFlag), int'(eErr));
  endtask

  task automatic driveAndModel(input bit st, input bit [NCH-1:0] ld, input int s0, input int s1);
    int cur;
    int na;
    int sv[NCH];
    sv[0] = s0; sv[1] = s1;
    periodStart = st;
    phaseLoad   = ld;
    phaseSetting = {SW'(s1), SW'(s0)};
    cur = st ? 0 : ((mCnt >= TO) ? TO : mCnt + 1);
    for (int c = 0; c < NCH; c++) begin
      na = st ? mPend[c] : mAct[c];
      ePulse[2*c]   = (cur == na);
      ePulse[2*c+1] = (cur == ((na + NSTEP/2) % NSTEP));
      eDeg[c] = (na * 360) / NSTEP;
      mAct[c] = na;
      if (ld[c]) mPend[c] = sv[c];
    end
    eErr = (cur == TO);
    mCnt = cur;
  endtask

  task automatic tick(input bit st, input bit [NCH-1:0] ld, input int s0, input int s1);
    @(negedge clk);
    compareAll();
    driveAndModel(st, ld, s0, s1);
  endtask

  // one reference period of len steps, settings bus left at s0/s1, no loads
  task automatic period(input int len, input int s0, input int s1);
    tick(1'b1, '0, s0, s1);
    for (int i = 1; i < len; i++) tick(1'b0, '0, s0, s1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mCnt = TO; eErr = 0;
    for (int c = 0; c < NCH; c++) begin mPend[c] = 0; mAct[c] = 0; eDeg[c] = 0; end
    for (int k = 0; k < 2*NCH; k++) ePulse[k] = 0;

    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "pulseOut in reset", int'(pulseOut), 0);
      chk("R1", "phaseDeg in reset", int'(phaseDeg), 0);
      chk("R1", "errFlag in reset", int'(errFlag), 0);
    end
    rstN = 1'b1;
    driveAndModel(1'b0, '0, 0, 0);

    // R9: error rises with no reference, no strobes
    for (int i = 0; i < 4; i++) tick(1'b0, '0, 0, 0);

    // R2/R3: defaults (0) then setting 32 on channel 1 for the inverted position
    tick(1'b0, 2'b10, 0, 32);
    period(64, 0, 32);
    period(64, 0, 32);
    // R2 boundary: 63 on ch0, 5 on ch1, loaded mid-period (R4: applies next start)
    for (int i = 0; i < 20; i++) tick(1'b0, '0, 0, 0);
    tick(1'b0, 2'b11, 63, 5);
    period(64, 7, 9);
    period(64, 7, 9);
    // R4: load in the same cycle as a start waits one more period
    tick(1'b1, 2'b01, 1, 0);
    for (int i = 1; i < 64; i++) tick(1'b0, '0, 1, 0);
    period(64, 1, 0);
    // R4: setting bus changes without load have no effect
    period(64, 40, 50);
    // R8: load only channel 1; channel 0 stays on 1
    tick(1'b1, 2'b10, 17, 60);
    for (int i = 1; i < 64; i++) tick(1'b0, '0, 17, 60);
    period(64, 0, 0);
    // long and short periods
    period(80, 0, 0);
    period(40, 0, 0);
    period(64, 0, 0);
    // R7: missing reference for longer than the timeout, then recovery
    for (int i = 0; i < 140; i++) tick(1'b0, '0, 0, 0);
    period(64, 0, 0);
    period(64, 0, 0);
    tick(1'b0, '0, 0, 0);
    @(negedge clk);
    compareAll();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule